// File: doc/BRIEF.md
# Shared Interrupt Controller

This block collects a vector of external interrupt lines and presents them to several processor targets. Software configures it through a word-addressed register bus. Each source has its own settings:

- an input sense, either active-high or active-low;
- a capture mode, either level-following or edge-latched;
- an enable bit;
- an output pin selection;
- an NMI flag;
- a bitmask of the targets it reaches.

A single write-only trigger register lets software raise any source. This is how one processor interrupts another. The same register, with its top bit clear, acknowledges an edge-latched source.

For each target the block drives:

- one line per output pin;
- an NMI line;
- a valid flag and the number of the lowest-numbered source currently requesting that target.

A read-only configuration word reports how many sources and targets the instance has. External lines pass through a two-flop synchronizer before any use.

Addresses are word addresses on a 10-bit bus. Bitmap registers hold one bit per source: source n sits in word n/32, bit n%32, and word w of a group is at the group base plus w.

Top module: `shirq_ctrl`

## Requirements
- R1: After reset every source is disabled, active-high and level-captured. All pin, NMI and valid outputs are low. The pin map and target mask of every source are zero.
- R2: The configuration word at 0x000 reads as (N_SRC/8-1) in bits [23:16] and (N_TGT-1) in bits [7:0]. All other bits read as zero.
- R3: Writing the trigger register at 0x001 with bit 31 set makes source wdata[7:0] pending on the next cycle. An index of N_SRC or more has no effect.
- R4: Writing the trigger register with bit 31 clear clears the latch of source wdata[7:0] on the next cycle. A level-captured source whose adjusted input is active stays pending.
- R5: A one written to the enable-set bank (0x030+w) enables that source, and a one written to the enable-clear bank (0x040+w) disables it. Zero bits change nothing. The enable state reads back at 0x020+w.
- R6: The pending word at 0x010+w is readable. For a level-captured source, the pending bit equals the synchronized input XOR its sense bit. It follows an input change within three clock edges.
- R7: The sense bank at 0x050+w (1 = active-low) and the capture bank at 0x060+w (1 = edge) are read-write. An edge source latches on a rising edge of its adjusted input and holds after the input returns to inactive.
- R8: The pin map of source n at 0x100+n has three fields: bit 31 routes to a pin, bit 30 routes to NMI, and bits [4:0] give the pin number. The register reads back exactly these fields.
- R9: Target mask bits [N_TGT-1:0] of source n are at 0x200+n. irq_o[t*N_PIN+p] is high while any source that is pending, enabled, routed to target t, pin-flagged and mapped to pin p exists. A pin number of N_PIN or more drives no line.
- R10: nmi_o[t] is high while any source that is pending, enabled, routed to target t and NMI-flagged exists. With every source disabled, no pin, NMI or valid output is high.
- R11: For each target, irq_vld_o[t] is high when any pending, enabled source is routed to t. irq_id_o[t*IDW +: IDW] gives the lowest such source number, with IDW = clog2(N_SRC).
- R12: Writes to the configuration, pending and enable-status addresses are ignored. Reads of the trigger, enable-set and enable-clear addresses, and of unmapped addresses, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 10 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_line_i | input | N_SRC | External interrupt lines |
| irq_o | output | N_TGT*N_PIN | Per-target pin outputs, index t*N_PIN+p |
| nmi_o | output | N_TGT | Per-target NMI |
| irq_vld_o | output | N_TGT | Target has an active request |
| irq_id_o | output | N_TGT*clog2(N_SRC) | Lowest active source per target |

## Verification
The assertions rely on the bus behaving as a simple single-master bus. Address and write data are taken as stable and defined whenever reg_we_i is high, and at most one write happens per cycle. The stimulus drives the bus and the interrupt lines only on falling edges and changes them one write at a time. It changes the sense bits only while the interrupt lines are at known levels. Any edge that such a change creates is then acknowledged before results are compared.

// File: rtl/shirq_pkg.sv
package shirq_pkg;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned PIN_FW = 5;

  localparam logic [1:0] RGN_MISC   = 2'd0;
  localparam logic [1:0] RGN_PINMAP = 2'd1;
  localparam logic [1:0] RGN_ROUTE  = 2'd2;

  localparam logic [3:0] GRP_CTRL  = 4'h0;
  localparam logic [3:0] GRP_PEND  = 4'h1;
  localparam logic [3:0] GRP_MSTAT = 4'h2;
  localparam logic [3:0] GRP_SMASK = 4'h3;
  localparam logic [3:0] GRP_RMASK = 4'h4;
  localparam logic [3:0] GRP_POL   = 4'h5;
  localparam logic [3:0] GRP_TRIG  = 4'h6;

  typedef struct packed {
    logic              to_pin;
    logic              to_nmi;
    logic [PIN_FW-1:0] pin;
  } pinmap_t;
endpackage

// File: rtl/shirq_src.sv
module shirq_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic low_act_i,
  input  logic edge_mode_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  output logic pend_o
);
  logic [1:0] sync_q;
  logic       act, act_prev_q, lat_q;

  assign act = sync_q[1] ^ low_act_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q     <= '0;
      act_prev_q <= 1'b0;
      lat_q      <= 1'b0;
    end else begin
      sync_q     <= {sync_q[0], line_i};
      act_prev_q <= act;
      // a new edge or set wins over a simultaneous clear
      lat_q      <= (lat_q & ~sw_clr_i) | sw_set_i | (edge_mode_i & act & ~act_prev_q);
    end
  end

  assign pend_o = lat_q | (~edge_mode_i & act);
endmodule

// File: rtl/shirq_ff1.sv
module shirq_ff1 #(
  parameter int unsigned N   = 32,
  localparam int unsigned IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]   req_i,
  output logic           vld_o,
  output logic [IDW-1:0] idx_o
);
  always_comb begin
    vld_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDW'(i);
    end
  end
endmodule

// File: rtl/shirq_tgt.sv
module shirq_tgt
  import shirq_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned N_PIN = 6,
  localparam int unsigned IDW = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]             req_i,
  input  logic [N_SRC-1:0]             to_pin_i,
  input  logic [N_SRC-1:0]             to_nmi_i,
  input  logic [N_SRC-1:0][PIN_FW-1:0] pin_i,
  output logic [N_PIN-1:0]             pins_o,
  output logic                         nmi_o,
  output logic                         vld_o,
  output logic [IDW-1:0]               idx_o
);
  always_comb begin
    pins_o = '0;
    nmi_o  = 1'b0;
    for (int n = 0; n < N_SRC; n++) begin
      if (req_i[n] && to_nmi_i[n]) nmi_o = 1'b1;
      if (req_i[n] && to_pin_i[n]) begin
        for (int p = 0; p < N_PIN; p++) begin
          if (pin_i[n] == PIN_FW'(p)) pins_o[p] = 1'b1;
        end
      end
    end
  end

  shirq_ff1 #(.N(N_SRC)) u_ff1 (
    .req_i (req_i),
    .vld_o (vld_o),
    .idx_o (idx_o)
  );
endmodule

// File: rtl/shirq_ctrl.sv
module shirq_ctrl
  import shirq_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned N_TGT = 4,
  parameter int unsigned N_PIN = 6
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              reg_we_i,
  input  logic [9:0]                        reg_addr_i,
  input  logic [31:0]                       reg_wdata_i,
  output logic [31:0]                       reg_rdata_o,
  input  logic [N_SRC-1:0]                  irq_line_i,
  output logic [N_TGT*N_PIN-1:0]            irq_o,
  output logic [N_TGT-1:0]                  nmi_o,
  output logic [N_TGT-1:0]                  irq_vld_o,
  output logic [N_TGT*$clog2(N_SRC)-1:0]    irq_id_o
);
  localparam int unsigned IDW   = $clog2(N_SRC);
  localparam int unsigned WORDS = (N_SRC + 31) / 32;
  localparam int unsigned VW    = WORDS * 32;
  localparam logic [31:0] CFG_WORD = (32'(N_SRC / 8 - 1) << 16) | 32'(N_TGT - 1);

  logic [N_SRC-1:0]            mask_q, pol_q, trig_q, pend, eff;
  logic [N_SRC-1:0]            sw_set, sw_clr;
  pinmap_t                     map_q [N_SRC];
  logic [N_SRC-1:0][N_TGT-1:0] route_q;

  logic [1:0] rgn;
  logic [3:0] grp, widx;
  logic [7:0] sidx;
  logic       trig_wr;

  assign rgn     = reg_addr_i[9:8];
  assign grp     = reg_addr_i[7:4];
  assign widx    = reg_addr_i[3:0];
  assign sidx    = reg_addr_i[7:0];
  assign trig_wr = reg_we_i && rgn == RGN_MISC && grp == GRP_CTRL && widx == 4'd1;

  always_comb begin
    for (int n = 0; n < N_SRC; n++) begin
      sw_set[n] = trig_wr &&  reg_wdata_i[31] && reg_wdata_i[7:0] == 8'(n);
      sw_clr[n] = trig_wr && !reg_wdata_i[31] && reg_wdata_i[7:0] == 8'(n);
    end
  end

  // register bank
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      pol_q   <= '0;
      trig_q  <= '0;
      route_q <= '0;
      for (int n = 0; n < N_SRC; n++) map_q[n] <= '0;
    end else if (reg_we_i) begin
      for (int n = 0; n < N_SRC; n++) begin
        if (rgn == RGN_MISC && widx == 4'(n / 32)) begin
          if (grp == GRP_SMASK && reg_wdata_i[n % 32]) mask_q[n] <= 1'b1;
          if (grp == GRP_RMASK && reg_wdata_i[n % 32]) mask_q[n] <= 1'b0;
          if (grp == GRP_POL)  pol_q[n]  <= reg_wdata_i[n % 32];
          if (grp == GRP_TRIG) trig_q[n] <= reg_wdata_i[n % 32];
        end
        if (rgn == RGN_PINMAP && sidx == 8'(n))
          map_q[n] <= '{to_pin: reg_wdata_i[31], to_nmi: reg_wdata_i[30],
                        pin: reg_wdata_i[PIN_FW-1:0]};
        if (rgn == RGN_ROUTE && sidx == 8'(n))
          route_q[n] <= reg_wdata_i[N_TGT-1:0];
      end
    end
  end

  for (genvar n = 0; n < N_SRC; n++) begin : g_src
    shirq_src u_src (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .line_i      (irq_line_i[n]),
      .low_act_i   (pol_q[n]),
      .edge_mode_i (trig_q[n]),
      .sw_set_i    (sw_set[n]),
      .sw_clr_i    (sw_clr[n]),
      .pend_o      (pend[n])
    );
  end

  assign eff = pend & mask_q;

  logic [N_SRC-1:0]             to_pin_v, to_nmi_v;
  logic [N_SRC-1:0][PIN_FW-1:0] pin_v;
  logic [N_TGT-1:0][N_SRC-1:0]  req_tgt;

  always_comb begin
    for (int n = 0; n < N_SRC; n++) begin
      to_pin_v[n] = map_q[n].to_pin;
      to_nmi_v[n] = map_q[n].to_nmi;
      pin_v[n]    = map_q[n].pin;
      for (int t = 0; t < N_TGT; t++) req_tgt[t][n] = eff[n] & route_q[n][t];
    end
  end

  for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
    shirq_tgt #(.N_SRC(N_SRC), .N_PIN(N_PIN)) u_tgt (
      .req_i    (req_tgt[t]),
      .to_pin_i (to_pin_v),
      .to_nmi_i (to_nmi_v),
      .pin_i    (pin_v),
      .pins_o   (irq_o[t*N_PIN +: N_PIN]),
      .nmi_o    (nmi_o[t]),
      .vld_o    (irq_vld_o[t]),
      .idx_o    (irq_id_o[t*IDW +: IDW])
    );
  end

  // read mux
  logic [VW-1:0] pend_pad, mask_pad, pol_pad, trig_pad;
  assign pend_pad = VW'(pend);
  assign mask_pad = VW'(mask_q);
  assign pol_pad  = VW'(pol_q);
  assign trig_pad = VW'(trig_q);

  always_comb begin
    reg_rdata_o = '0;
    unique case (rgn)
      RGN_MISC: begin
        if (grp == GRP_CTRL && widx == 4'd0) reg_rdata_o = CFG_WORD;
        for (int w = 0; w < WORDS; w++) begin
          if (widx == 4'(w)) begin
            if (grp == GRP_PEND)  reg_rdata_o = pend_pad[w*32 +: 32];
            if (grp == GRP_MSTAT) reg_rdata_o = mask_pad[w*32 +: 32];
            if (grp == GRP_POL)   reg_rdata_o = pol_pad[w*32 +: 32];
            if (grp == GRP_TRIG)  reg_rdata_o = trig_pad[w*32 +: 32];
          end
        end
      end
      RGN_PINMAP: begin
        for (int n = 0; n < N_SRC; n++) begin
          if (sidx == 8'(n))
            reg_rdata_o = {map_q[n].to_pin, map_q[n].to_nmi,
                           {(32-2-PIN_FW){1'b0}}, map_q[n].pin};
        end
      end
      RGN_ROUTE: begin
        for (int n = 0; n < N_SRC; n++) begin
          if (sidx == 8'(n)) reg_rdata_o = 32'(route_q[n]);
        end
      end
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/shirq_ctrl_chk.sv
module shirq_ctrl_chk #(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned N_TGT = 4,
  parameter int unsigned N_PIN = 6
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   reg_we_i,
  input logic [9:0]             reg_addr_i,
  input logic [31:0]            reg_wdata_i,
  input logic [31:0]            reg_rdata_o,
  input logic [N_SRC-1:0]       mask_q,
  input logic [N_SRC-1:0]       pend,
  input logic [N_TGT*N_PIN-1:0] irq_o,
  input logic [N_TGT-1:0]       nmi_o,
  input logic [N_TGT-1:0]       irq_vld_o
);
  logic [31:0] mask_lo;
  assign mask_lo = 32'(mask_q);

  // R3
  a_r3_sw_set_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 10'h001 && reg_wdata_i[31] && reg_wdata_i[7:0] < 8'(N_SRC))
    |=> ((pend >> $past(reg_wdata_i[7:0])) & 1) != 0);

  // R5
  a_r5_clear_all_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 10'h040 && reg_wdata_i == 32'hFFFF_FFFF) |=> mask_lo == 32'h0);

  // R5
  a_r5_zero_write_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && (reg_addr_i == 10'h030 || reg_addr_i == 10'h040) && reg_wdata_i == 32'h0)
    |=> $stable(mask_q));

  // R10
  a_r10_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> (irq_o == '0 && nmi_o == '0 && irq_vld_o == '0));

  // R10
  a_r10_nmi_needs_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|nmi_o) |-> (|(pend & mask_q)));

  // R11
  a_r11_vld_needs_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_vld_o) |-> (|(pend & mask_q)));

  // R12
  a_r12_wo_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 10'h001 || reg_addr_i[9:4] == 6'h03 || reg_addr_i[9:4] == 6'h04)
    |-> reg_rdata_o == 32'h0);
endmodule

bind shirq_ctrl shirq_ctrl_chk #(.N_SRC(N_SRC), .N_TGT(N_TGT), .N_PIN(N_PIN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .mask_q      (mask_q),
  .pend        (pend),
  .irq_o       (irq_o),
  .nmi_o       (nmi_o),
  .irq_vld_o   (irq_vld_o)
);

// File: tb/shirq_ctrl_test.sv
module shirq_ctrl_test;
  localparam int N_SRC = 32, N_TGT = 4, N_PIN = 6, IDW = 5;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N_SRC-1:0]       lines = '0;
  logic [N_TGT*N_PIN-1:0] irq;
  logic [N_TGT-1:0]       nmi, vld;
  logic [N_TGT*IDW-1:0]   ids;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  shirq_ctrl #(.N_SRC(N_SRC), .N_TGT(N_TGT), .N_PIN(N_PIN)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_line_i(lines),
    .irq_o(irq), .nmi_o(nmi), .irq_vld_o(vld), .irq_id_o(ids)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic clear_all();
    for (int n = 0; n < N_SRC; n++) wr(10'h001, 32'(n));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, pol, exp_id;
    logic [31:0] pats [4];
    logic [31:0] edge_pats [3];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h8000_0010;
    pats[2] = 32'h0F0F_00F0; pats[3] = 32'h1234_5678;
    edge_pats[0] = 32'hA5A5_0F0F; edge_pats[1] = 32'h0000_0001;
    edge_pats[2] = 32'h8000_0000;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;

    // R1, R2 reset state
    chk("R1 irq", 64'(irq), 0); chk("R1 nmi", 64'(nmi), 0); chk("R1 vld", 64'(vld), 0);
    rd(10'h020, d); chk("R1 enables", 64'(d), 0);
    rd(10'h050, d); chk("R1 sense", 64'(d), 0);
    rd(10'h060, d); chk("R1 capture", 64'(d), 0);
    rd(10'h105, d); chk("R1 pinmap", 64'(d), 0);
    rd(10'h21F, d); chk("R1 route", 64'(d), 0);
    rd(10'h000, d); chk("R2 config", 64'(d), 64'((32'(N_SRC/8-1) << 16) | 32'(N_TGT-1)));

    // R12 read-only writes ignored, write-only reads zero
    wr(10'h000, 32'hFFFF_FFFF); wr(10'h010, 32'hFFFF_FFFF); wr(10'h020, 32'hFFFF_FFFF);
    rd(10'h000, d); chk("R12 config kept", 64'(d), 64'h0003_0003);
    rd(10'h010, d); chk("R12 pend kept", 64'(d), 0);
    rd(10'h020, d); chk("R12 enables kept", 64'(d), 0);
    rd(10'h001, d); chk("R12 trigger reads 0", 64'(d), 0);
    rd(10'h030, d); chk("R12 set bank reads 0", 64'(d), 0);
    rd(10'h040, d); chk("R12 clear bank reads 0", 64'(d), 0);
    rd(10'h3FF, d); chk("R12 unmapped reads 0", 64'(d), 0);

    // R5 enable banks
    wr(10'h030, 32'h0000_00A5); rd(10'h020, d); chk("R5 set", 64'(d), 64'h0A5);
    wr(10'h030, 32'h0000_0F00); rd(10'h020, d); chk("R5 set more", 64'(d), 64'hFA5);
    wr(10'h040, 32'h0000_0005); rd(10'h020, d); chk("R5 clear", 64'(d), 64'hFA0);
    wr(10'h040, 32'h0); wr(10'h030, 32'h0); rd(10'h020, d); chk("R5 zero no effect", 64'(d), 64'hFA0);
    wr(10'h040, 32'hFFFF_FFFF); rd(10'h020, d); chk("R5 clear all", 64'(d), 0);

    // R3 R4 R8 R9 R11 sweep: source n -> target n%4, pin n%6, edge capture
    wr(10'h060, 32'hFFFF_FFFF);
    rd(10'h060, d); chk("R7 capture readback", 64'(d), 64'hFFFF_FFFF);
    for (int n = 0; n < N_SRC; n++) begin
      wr(10'h100 + 10'(n), 32'h8000_0000 | 32'(n % 6));
      wr(10'h200 + 10'(n), 32'(1) << (n % 4));
    end
    rd(10'h10B, d); chk("R8 pinmap readback", 64'(d), 64'h8000_0005);
    rd(10'h20B, d); chk("R9 route readback", 64'(d), 64'h8);
    wr(10'h030, 32'hFFFF_FFFF);
    for (int n = 0; n < N_SRC; n++) begin
      wr(10'h001, 32'h8000_0000 | 32'(n));
      #1;
      chk("R9 pin line", 64'(irq), 64'(1) << ((n % 4) * N_PIN + (n % 6)));
      chk("R11 valid", 64'(vld), 64'(1) << (n % 4));
      chk("R11 id", 64'(ids[(n % 4)*IDW +: IDW]), 64'(n));
      rd(10'h010, d); chk("R3 pending", 64'(d), 64'(32'(1) << n));
      wr(10'h001, 32'(n));
      rd(10'h010, d); chk("R4 ack clears", 64'(d), 0);
      chk("R9 pin released", 64'(irq), 0);
    end
    wr(10'h001, 32'h8000_0000 | 32'd40);
    rd(10'h010, d); chk("R3 out-of-range index", 64'(d), 0);

    // R11 priority patterns
    foreach (pats[k]) begin
      for (int n = N_SRC - 1; n >= 0; n--)
        if (pats[k][n]) wr(10'h001, 32'h8000_0000 | 32'(n));
      rd(10'h010, d); chk("R3 pattern pending", 64'(d), 64'(pats[k]));
      for (int t = 0; t < N_TGT; t++) begin
        exp_id = 32'hFFFF_FFFF;
        for (int n = N_SRC - 1; n >= 0; n--)
          if (pats[k][n] && (n % 4) == t) exp_id = 32'(n);
        chk("R11 pattern valid", 64'(vld[t]), 64'(exp_id != 32'hFFFF_FFFF));
        if (exp_id != 32'hFFFF_FFFF) chk("R11 pattern id", 64'(ids[t*IDW +: IDW]), 64'(exp_id));
      end
      clear_all();
    end

    // R6 level capture with mixed sense
    wr(10'h060, 32'h0);
    pol = 32'hF0F0_F0F0;
    wr(10'h050, pol);
    rd(10'h050, d); chk("R7 sense readback", 64'(d), 64'(pol));
    foreach (pats[k]) begin
      @(negedge clk); lines = pats[k];
      settle();
      rd(10'h010, d); chk("R6 level follows", 64'(d), 64'(pats[k] ^ pol));
    end
    @(negedge clk); lines = 32'h0;
    settle();
    wr(10'h001, 32'd4);
    rd(10'h010, d); chk("R4 level not cleared", 64'(d), 64'(pol));

    // R7 edge capture active-high
    wr(10'h050, 32'h0);
    wr(10'h060, 32'hFFFF_FFFF);
    clear_all();
    foreach (edge_pats[k]) begin
      @(negedge clk); lines = edge_pats[k];
      settle();
      rd(10'h010, d); chk("R7 edge latched", 64'(d), 64'(edge_pats[k]));
      @(negedge clk); lines = 32'h0;
      settle();
      rd(10'h010, d); chk("R7 edge held", 64'(d), 64'(edge_pats[k]));
      clear_all();
      rd(10'h010, d); chk("R4 edge acked", 64'(d), 0);
    end

    // R7 edge capture active-low
    @(negedge clk); lines = 32'hFFFF_FFFF;
    settle();
    clear_all();
    wr(10'h050, 32'hFFFF_FFFF);
    settle();
    rd(10'h010, d); chk("R7 no spurious edge", 64'(d), 0);
    @(negedge clk); lines = ~32'h00C3_0018;
    settle();
    rd(10'h010, d); chk("R7 falling edge latched", 64'(d), 64'h00C3_0018);
    clear_all();

    // R10 NMI and out-of-range pin
    wr(10'h103, 32'h4000_0000); wr(10'h203, 32'hF);
    rd(10'h103, d); chk("R8 nmi map readback", 64'(d), 64'h4000_0000);
    wr(10'h001, 32'h8000_0003);
    #1;
    chk("R10 nmi all targets", 64'(nmi), 64'hF);
    chk("R9 nmi-only no pin", 64'(irq), 0);
    chk("R11 nmi valid", 64'(vld), 64'hF);
    wr(10'h040, 32'h0000_0008);
    #1;
    chk("R10 disabled nmi", 64'(nmi), 0);
    chk("R11 disabled valid", 64'(vld), 0);
    wr(10'h105, 32'h8000_0007); wr(10'h205, 32'hF);
    wr(10'h001, 32'h8000_0005);
    #1;
    chk("R9 pin beyond range", 64'(irq), 0);
    chk("R11 id with unmapped pin", 64'(ids[0 +: IDW]), 64'd5);
    wr(10'h040, 32'hFFFF_FFFF);
    #1;
    chk("R10 all disabled quiet", 64'({irq, nmi, vld}), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule